// File: doc/BRIEF.md
# Program Counter Sequencer with Return-Address Stack

This block holds the instruction address of a small processor and chooses the next one on every clock edge. The address is 12 bits wide, so it covers 4096 instruction words. A 3-bit command picks how the address moves:

- step forward by one,
- jump unconditionally,
- branch on one of the four status flags,
- call a subroutine,
- return from a subroutine.

Decode logic outside the block supplies the command, the 12-bit target field and the current zero, carry, negative and positive flags.

Return addresses are kept in a last-in-first-out stack inside the block. No load or store path can reach this stack. A call saves the address after the call into the slot named by the stack pointer, then advances the pointer. A return first moves the pointer back, then reads that slot. The default depth is eight, so up to eight subroutine calls can be nested. Misuse of the stack is reported through two sticky flags:

- a call made while the stack is full sets the overflow flag;
- a return made while the stack is empty sets the underflow flag.

Top module: `seq_addr_unit`

## Requirements
- R1: After reset the address output is 0, both error flags are 0 and the stack holds no entries.
- R2: Command 0 (step) advances the address by one, and 4095 wraps to 0. Commands 5, 6 and 7 are unused and behave exactly like step.
- R3: Command 1 (jump) loads the target input into the address on the next edge.
- R4: Command 2 (branch) loads the target if its condition holds, otherwise it steps by one. The condition codes are:
  - code 0: Z=1
  - code 1: Z=0
  - code 2: C=1
  - code 3: C=0
  - code 4: N=1
  - code 5: P=1
  - codes 6 and 7: never taken.
- R5: Command 3 (call) pushes the current address plus one and loads the target into the address.
- R6: Command 4 (return) on a non-empty stack loads the address from the most recent pushed entry. Nested calls unwind in reverse order.
- R7: A call while the stack holds the full parameter depth of entries still loads the target, but writes nothing and leaves the pointer unchanged. It sets the overflow flag, and the entries already stored stay intact.
- R8: A return on an empty stack steps the address by one and sets the underflow flag.
- R9: Both error flags stay set until the next reset, which clears them.
- R10: A call issued at address 4095 pushes the wrapped value 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 3 | Command: 0 step, 1 jump, 2 branch, 3 call, 4 return, 5-7 step |
| cond_i | input | 3 | Branch condition code, used with command 2 |
| target_i | input | 12 | Jump, branch or call destination |
| z_i | input | 1 | Zero flag |
| c_i | input | 1 | Carry flag |
| n_i | input | 1 | Negative flag |
| p_i | input | 1 | Positive flag |
| pc_o | output | 12 | Current instruction address |
| ovf_o | output | 1 | Sticky stack overflow flag |
| unf_o | output | 1 | Sticky stack underflow flag |

## Verification
The bench sweeps every condition code against all sixteen flag combinations. A condition wired to the wrong flag or the wrong polarity shows up as a branch taken where a step was expected, or the reverse.

It nests calls to the full depth and adds one more. It then unwinds every level. A design that pushes after incrementing the pointer, or that lets the extra call overwrite the top slot, returns to the wrong address. A design that miscounts fullness fails to raise overflow.

The bench also covers three boundary cases:
- wrap-around at address 4095 on both step and call;
- a return on an empty stack, which must step the address and never read stale data;
- a mid-run reset, which must clear the sticky flags and the stack.

// File: rtl/seq_addr_pkg.sv
package seq_addr_pkg;

   typedef enum logic [2:0] {
      CMD_STEP   = 3'd0,
      CMD_JUMP   = 3'd1,
      CMD_BRANCH = 3'd2,
      CMD_CALL   = 3'd3,
      CMD_RETURN = 3'd4
   } seq_cmd_e;

   typedef enum logic [2:0] {
      CND_ZERO     = 3'd0,
      CND_NONZERO  = 3'd1,
      CND_CARRY    = 3'd2,
      CND_NOCARRY  = 3'd3,
      CND_NEGATIVE = 3'd4,
      CND_POSITIVE = 3'd5
   } seq_cond_e;

   typedef struct packed {
      logic z;
      logic c;
      logic n;
      logic p;
   } seq_flags_t;

endpackage

// File: rtl/seq_cond_eval.sv
module seq_cond_eval
   import seq_addr_pkg::*;
(
   input  logic [2:0] cond_i,
   input  seq_flags_t flags_i,
   output logic       taken_o
);

   always_comb begin
      case (seq_cond_e'(cond_i))
         CND_ZERO:     taken_o = flags_i.z;
         CND_NONZERO:  taken_o = ~flags_i.z;
         CND_CARRY:    taken_o = flags_i.c;
         CND_NOCARRY:  taken_o = ~flags_i.c;
         CND_NEGATIVE: taken_o = flags_i.n;
         CND_POSITIVE: taken_o = flags_i.p;
         default:      taken_o = 1'b0;
      endcase
   end

   // R4: the reserved codes 6 and 7 never select the target
   always_comb begin
      a_r4_reserved_never : assert (!(cond_i[2] && cond_i[1]) || !taken_o);
   end

endmodule

// File: rtl/seq_ret_stack.sv
module seq_ret_stack #(
   parameter int DATA_W = 12,
   parameter int DEPTH  = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              push_i,
   input  logic              pop_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              empty_o,
   output logic              full_o,
   output logic              ovf_o,
   output logic              unf_o
);

   localparam int SP_W = $clog2(DEPTH + 1);
   localparam logic [SP_W-1:0] SP_FULL = SP_W'(DEPTH);

   logic [SP_W-1:0]   sp_q;
   logic [SP_W-1:0]   rd_idx;
   logic [DATA_W-1:0] slot_view [DEPTH];
   logic              ovf_q, unf_q;

   initial begin
      a_r7_depth_ok : assert (DEPTH >= 1)
         else $error("seq_ret_stack: DEPTH must be at least 1");
      a_r3_width_ok : assert (DATA_W >= 2)
         else $error("seq_ret_stack: DATA_W must be at least 2");
   end

   assign empty_o = (sp_q == '0);
   assign full_o  = (sp_q == SP_FULL);

   // one register per slot, written only when the pointer names it
   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic [DATA_W-1:0] slot_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            slot_q <= '0;
         end else if (push_i && !full_o && (sp_q == SP_W'(g))) begin
            slot_q <= wr_data_i;
         end
      end
      assign slot_view[g] = slot_q;
   end

   // a return reads the slot just below the pointer
   assign rd_idx = empty_o ? '0 : (sp_q - SP_W'(1));

   always_comb begin
      rd_data_o = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (rd_idx == SP_W'(i)) rd_data_o = slot_view[i];
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sp_q <= '0;
      end else if (push_i && !full_o) begin
         sp_q <= sp_q + SP_W'(1);
      end else if (pop_i && !empty_o) begin
         sp_q <= sp_q - SP_W'(1);
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ovf_q <= 1'b0;
         unf_q <= 1'b0;
      end else begin
         if (push_i && full_o) ovf_q <= 1'b1;
         if (pop_i && empty_o) unf_q <= 1'b1;
      end
   end

   assign ovf_o = ovf_q;
   assign unf_o = unf_q;

   a_r7_sp_bound : assert property (@(posedge clk_i) disable iff (!rst_ni)
      sp_q <= SP_FULL);
   a_r5_push_grows : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (push_i && !full_o) |=> (sp_q == $past(sp_q) + SP_W'(1)));
   a_r7_no_overflow : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (push_i && full_o) |=> ($stable(sp_q) && ovf_o));
   a_r8_empty_pop : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pop_i && empty_o) |=> (empty_o && unf_o));
   a_r9_ovf_sticky : assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovf_o |=> ovf_o);
   a_r9_unf_sticky : assert property (@(posedge clk_i) disable iff (!rst_ni)
      unf_o |=> unf_o);

endmodule

// File: rtl/seq_next_addr.sv
module seq_next_addr
   import seq_addr_pkg::*;
#(
   parameter int ADDR_W = 12
) (
   input  logic [ADDR_W-1:0] pc_i,
   input  logic [2:0]        cmd_i,
   input  logic              taken_i,
   input  logic [ADDR_W-1:0] target_i,
   input  logic [ADDR_W-1:0] pop_data_i,
   input  logic              empty_i,
   output logic [ADDR_W-1:0] pc_inc_o,
   output logic [ADDR_W-1:0] pc_next_o,
   output logic              push_o,
   output logic              pop_o
);

   assign pc_inc_o = pc_i + ADDR_W'(1);

   always_comb begin
      push_o    = 1'b0;
      pop_o     = 1'b0;
      pc_next_o = pc_inc_o;
      case (seq_cmd_e'(cmd_i))
         CMD_JUMP:   pc_next_o = target_i;
         CMD_BRANCH: pc_next_o = taken_i ? target_i : pc_inc_o;
         CMD_CALL: begin
            push_o    = 1'b1;
            pc_next_o = target_i;
         end
         CMD_RETURN: begin
            pop_o     = 1'b1;
            pc_next_o = empty_i ? pc_inc_o : pop_data_i;
         end
         default:    pc_next_o = pc_inc_o;
      endcase
   end

   // R5/R6: a single command never pushes and pops at once
   always_comb begin
      a_r6_push_pop_excl : assert (!(push_o && pop_o));
   end

endmodule

// File: rtl/seq_addr_unit.sv
module seq_addr_unit
   import seq_addr_pkg::*;
#(
   parameter int ADDR_W      = 12,
   parameter int STACK_DEPTH = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [2:0]        cmd_i,
   input  logic [2:0]        cond_i,
   input  logic [ADDR_W-1:0] target_i,
   input  logic              z_i,
   input  logic              c_i,
   input  logic              n_i,
   input  logic              p_i,
   output logic [ADDR_W-1:0] pc_o,
   output logic              ovf_o,
   output logic              unf_o
);

   logic [ADDR_W-1:0] pc_q, pc_next, pc_inc, pop_data;
   logic              taken, push, pop, st_empty, st_full;
   seq_flags_t        flags;

   initial begin
      a_r2_addr_w_ok : assert (ADDR_W >= 2 && ADDR_W <= 32)
         else $error("seq_addr_unit: ADDR_W out of range");
   end

   assign flags = '{z: z_i, c: c_i, n: n_i, p: p_i};

   seq_cond_eval u_cond (
      .cond_i  (cond_i),
      .flags_i (flags),
      .taken_o (taken)
   );

   seq_next_addr #(.ADDR_W(ADDR_W)) u_next (
      .pc_i       (pc_q),
      .cmd_i      (cmd_i),
      .taken_i    (taken),
      .target_i   (target_i),
      .pop_data_i (pop_data),
      .empty_i    (st_empty),
      .pc_inc_o   (pc_inc),
      .pc_next_o  (pc_next),
      .push_o     (push),
      .pop_o      (pop)
   );

   seq_ret_stack #(.DATA_W(ADDR_W), .DEPTH(STACK_DEPTH)) u_stack (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .push_i    (push),
      .pop_i     (pop),
      .wr_data_i (pc_inc),
      .rd_data_o (pop_data),
      .empty_o   (st_empty),
      .full_o    (st_full),
      .ovf_o     (ovf_o),
      .unf_o     (unf_o)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pc_q <= '0;
      else         pc_q <= pc_next;
   end

   assign pc_o = pc_q;

   a_r3_jump_loads : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_i == 3'd1) |=> (pc_o == $past(target_i)));
   a_r5_call_loads : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_i == 3'd3) |=> (pc_o == $past(target_i)));
   a_r2_step_wraps : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_i == 3'd0 || cmd_i > 3'd4) |=> (pc_o == $past(pc_o) + ADDR_W'(1)));
   a_r4_not_taken : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_i == 3'd2 && !taken) |=> (pc_o == $past(pc_o) + ADDR_W'(1)));
   a_r8_empty_return : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_i == 3'd4 && st_empty) |=> (pc_o == $past(pc_o) + ADDR_W'(1)));
   a_r7_full_flag : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_i == 3'd3 && st_full) |=> ovf_o);

endmodule

// File: tb/seq_addr_unit_tb.sv
module seq_addr_unit_tb;

   localparam int AW    = 12;
   localparam int DEPTH = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [2:0]    cmd = '0;
   logic [2:0]    cond = '0;
   logic [AW-1:0] tgt = '0;
   logic          z = 0, c = 0, n = 0, p = 0;
   logic [AW-1:0] pc;
   logic          ovf, unf;

   int checks = 0;
   int errors = 0;

   int exp_pc;
   int exp_sp;
   int exp_stk [DEPTH];
   bit exp_ovf, exp_unf;

   always #10 clk = ~clk;

   seq_addr_unit #(.ADDR_W(AW), .STACK_DEPTH(DEPTH)) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .cond_i(cond), .target_i(tgt),
      .z_i(z), .c_i(c), .n_i(n), .p_i(p),
      .pc_o(pc), .ovf_o(ovf), .unf_o(unf)
   );

   task automatic chk(input string tag, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic chk_all(input string tag);
      chk({tag, " pc"}, int'(pc), exp_pc);
      chk({tag, " ovf"}, int'(ovf), int'(exp_ovf));
      chk({tag, " unf"}, int'(unf), int'(exp_unf));
   endtask

   function automatic bit cond_true(input int cc, input bit fz, input bit fc,
                                    input bit fn, input bit fp);
      case (cc)
         0: return fz;
         1: return !fz;
         2: return fc;
         3: return !fc;
         4: return fn;
         5: return fp;
         default: return 1'b0;
      endcase
   endfunction

   // drive at the falling edge, let one rising edge pass, compare at the next falling edge
   task automatic op(input int k, input int cc, input int t, input int fl, input string tag);
      int inc;
      inc = (exp_pc + 1) % 4096;
      cmd = 3'(k); cond = 3'(cc); tgt = AW'(t);
      {z, c, n, p} = 4'(fl);
      case (k)
         1: exp_pc = t;
         2: exp_pc = cond_true(cc, fl[3], fl[2], fl[1], fl[0]) ? t : inc;
         3: begin
            if (exp_sp == DEPTH) exp_ovf = 1;
            else begin exp_stk[exp_sp] = inc; exp_sp++; end
            exp_pc = t;
         end
         4: begin
            if (exp_sp == 0) begin exp_unf = 1; exp_pc = inc; end
            else begin exp_sp--; exp_pc = exp_stk[exp_sp]; end
         end
         default: exp_pc = inc;
      endcase
      @(posedge clk);
      @(negedge clk);
      chk_all(tag);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      cmd = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      exp_pc = 0; exp_sp = 0; exp_ovf = 0; exp_unf = 0;
      @(negedge clk);
      exp_pc = 1;  // one step already elapsed with cmd 0
   endtask

   initial begin
      #(20 * 200000);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // R1 reset state, sampled while reset is held
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      exp_pc = 0; exp_sp = 0; exp_ovf = 0; exp_unf = 0;
      chk_all("R1 reset");
      rst_n = 1'b1;
      cmd = 3'd1; tgt = '0;  // hold address at 0 for one edge
      @(posedge clk); @(negedge clk);
      chk_all("R1 after release");

      // R2 steps, including unused commands 5..7
      op(0, 0, 0, 0, "R2 step");
      op(0, 0, 0, 0, "R2 step");
      for (int k = 5; k < 8; k++) op(k, 0, 12'h555, 4'hF, "R2 unused cmd");

      // R3 jump and R2 wrap
      op(1, 0, 12'hFFE, 0, "R3 jump");
      op(0, 0, 0, 0, "R2 step to top");
      op(0, 0, 0, 0, "R2 wrap");

      // R8 return on empty stack, R9 stickiness
      op(4, 0, 12'h777, 0, "R8 empty return");
      op(0, 0, 0, 0, "R9 unf held");

      // R4 sweep of every condition code against every flag pattern
      for (int cc = 0; cc < 8; cc++) begin
         for (int fl = 0; fl < 16; fl++) begin
            op(2, cc, (cc * 16 + fl) * 13 + 100, fl, "R4 branch");
         end
      end

      // R5 nested calls to full depth
      for (int d = 0; d < DEPTH; d++) op(3, 0, 12'h200 + d * 37, 0, "R5 call");
      // R7 one call too many
      op(3, 0, 12'hABC, 0, "R7 overflow call");
      // R6 unwind in reverse order; entries survive the refused push
      for (int d = 0; d < DEPTH; d++) op(4, 0, 0, 0, "R6 return");
      op(4, 0, 0, 0, "R8 return past bottom");
      op(0, 0, 0, 0, "R9 both held");

      // R10 call from the top address pushes 0
      op(1, 0, 12'hFFF, 0, "R10 jump top");
      op(3, 0, 12'h123, 0, "R10 call");
      op(4, 0, 0, 0, "R10 return wraps");

      // R9 / R1 reset mid-run clears flags and stack
      op(3, 0, 12'h050, 0, "R5 call before reset");
      do_reset();
      op(0, 0, 0, 0, "R9 flags cleared");
      op(4, 0, 0, 0, "R1 stack empty after reset");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule